// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block carries out the hardware part of entering an exception handler. It is given an accepted vector number together with the kind of event that produced it: a fault, a trap, a hardware interrupt or an abort. It checks that the vector lies inside a descriptor table held in memory, then reads the two 32-bit words of that vector's gate descriptor through a word-read port. If the descriptor is valid, it decides whether the handler's privilege level differs from the current one, builds the return frame and writes it word by word through a word-write port. It then presents the handler's code selector, instruction pointer, stack segment, stack pointer and flags.

A surrounding core asserts `start_i` for one cycle while `busy_o` is low. It keeps its architectural state on the inputs and waits for `done_o`. If the vector is outside the table or its descriptor is not marked present, the sequence stops early and signals a general-protection condition. No frame is written in that case and the handler outputs keep their values. A page-fault vector also captures the faulting linear address into a dedicated register output.

Top module: `exc_entry_seq`

## Requirements
- R1: On an accepted start with vector v, when v*8+7 does not exceed the byte limit, the block issues two reads: the low word at base+v*8, then the high word at base+v*8+4. When v*8+7 exceeds the limit, no read is issued and the sequence ends as a general-protection abort.
- R2: Descriptor format. In the low word, bits 15:0 hold offset[15:0] and bits 31:16 hold the handler selector. In the high word, bits 31:16 hold offset[31:16], bit 15 is the present flag, bits 14:13 are the privilege field, and bit 8 is the gate type (0 interrupt, 1 trap). On success, new_cs_o is the selector and new_ip_o is the offset.
- R3: A descriptor whose present flag is 0 ends the sequence as a general-protection abort after both reads. No write is issued, and the new_* outputs keep their previous values.
- R4: When the selector's bits 1:0 differ from cur_cs_i bits 1:0, new_ss_o and the starting stack pointer come from kern_ss_i and kern_sp_i. The first two pushes are the old stack segment (zero-extended) and then the old stack pointer.
- R5: When the privilege bits are equal, new_ss_o equals cur_ss_i and pushing starts from cur_sp_i.
- R6: After the optional stack pair, the pushes are, in order: flags, code selector (zero-extended), saved instruction pointer, and the error code when has_err_i is 1. Each push first lowers the stack pointer by 4 and then writes at the new value, one write per cycle at addresses falling by 4. new_sp_o is the address of the last write.
- R7: The saved instruction pointer is cur_ip_i for class 0 (fault) and class 3 (abort), and next_ip_i for class 1 (trap) and class 2 (hardware interrupt).
- R8: For an interrupt gate, new_flags_o is cur_flags_i with bit 9 cleared. For a trap gate, new_flags_o equals cur_flags_i. The pushed flags word is always the unmodified cur_flags_i.
- R9: An accepted start with vector 14 loads fault_addr_i into fault_lin_o. Any other vector leaves fault_lin_o unchanged.
- R10: busy_o is high from the cycle after the accepted start through the done_o cycle. done_o is high for exactly one cycle, and start_i is ignored while busy_o is high.
- R11: In the done_o cycle, gp_o is 1 and fault_vec_o is 13 for an abort. Otherwise gp_o is 0 and fault_vec_o is the accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an entry sequence (sampled while idle) |
| vec_i | input | 8 | Accepted vector number |
| cls_i | input | 2 | Event class: 0 fault, 1 trap, 2 hardware interrupt, 3 abort |
| has_err_i | input | 1 | An error code is pushed |
| err_code_i | input | 32 | Error code value |
| fault_addr_i | input | 32 | Faulting linear address for a page fault |
| tbl_base_i | input | 32 | Descriptor table byte base address |
| tbl_limit_i | input | 16 | Descriptor table byte limit (last valid offset) |
| cur_cs_i | input | 16 | Current code selector |
| cur_ss_i | input | 16 | Current stack segment |
| cur_sp_i | input | 32 | Current stack pointer |
| cur_flags_i | input | 32 | Current flags |
| cur_ip_i | input | 32 | Address of the current instruction |
| next_ip_i | input | 32 | Address of the next instruction |
| kern_ss_i | input | 16 | Kernel stack segment |
| kern_sp_i | input | 32 | Kernel stack pointer |
| rd_en_o | output | 1 | Read request, one cycle |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data valid, one or more cycles after the request |
| rd_data_i | input | 32 | Read data |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| gp_o | output | 1 | General-protection abort, valid with done_o |
| fault_vec_o | output | 8 | Vector of the outcome, valid with done_o |
| new_cs_o | output | 16 | Handler code selector |
| new_ip_o | output | 32 | Handler instruction pointer |
| new_ss_o | output | 16 | Handler stack segment |
| new_sp_o | output | 32 | Handler stack pointer |
| new_flags_o | output | 32 | Handler flags |
| fault_lin_o | output | 32 | Latched faulting linear address |

## Verification
Results are due at fixed cycle counts. Number cycle 1 as the cycle after the start edge and let D be the extra read latency beyond one cycle. The first read is in cycle 1 and the second in cycle 3+D. An out-of-limit abort signals done in cycle 1, and a not-present abort in cycle 5+2D. The n frame writes occupy cycles 5+2D through 4+2D+n, with done in cycle 5+2D+n. The bench derives this schedule and the expected frame from the requirements alone, then compares strobes, addresses, data, busy and done in every one of those cycles, sampling between edges. The handler outputs are compared in the done cycle, with read latencies of both zero and several extra cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN        = 32;
    localparam int SEL_W       = 16;
    localparam int VEC_W       = 8;
    localparam int FRAME_SLOTS = 6;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);

    // frame slot positions, in push order
    localparam int SLOT_SS  = 0;
    localparam int SLOT_SP  = 1;
    localparam int SLOT_FL  = 2;
    localparam int SLOT_CS  = 3;
    localparam int SLOT_IP  = 4;
    localparam int SLOT_ERR = 5;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [FRAME_SLOTS-1:0][XLEN-1:0] frame_t;

    typedef enum logic [1:0] {
        CLS_FAULT = 2'd0,
        CLS_TRAP  = 2'd1,
        CLS_IRQ   = 2'd2,
        CLS_ABORT = 2'd3
    } exc_cls_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_PUSH,
        S_DONE
    } seq_st_e;

    typedef struct packed {
        sel_t       sel;
        word_t      off;
        logic       present;
        logic [1:0] dpl;
        logic       trap;
    } gate_t;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        exc_cls_e         cls;
        logic             has_err;
        word_t            err;
        sel_t             cs;
        sel_t             ss;
        word_t            sp;
        word_t            flags;
        word_t            ip;
        word_t            nip;
        sel_t             kss;
        word_t            ksp;
    } req_t;

    function automatic gate_t gate_decode(input word_t lo, input word_t hi);
        gate_t g;
        g.sel     = lo[31:16];
        g.off     = {hi[31:16], lo[15:0]};
        g.present = hi[15];
        g.dpl     = hi[14:13];
        g.trap    = hi[8];
        return g;
    endfunction

    function automatic word_t sel_zext(input sel_t s);
        return {{(XLEN-SEL_W){1'b0}}, s};
    endfunction

    function automatic logic saves_next_ip(input exc_cls_e c);
        return (c == CLS_TRAP) || (c == CLS_IRQ);
    endfunction

endpackage

// File: rtl/exc_gate_fetch.sv
module exc_gate_fetch
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go_i,
    input  word_t base_addr_i,
    output logic  rd_en_o,
    output word_t rd_addr_o,
    input  logic  rd_valid_i,
    input  word_t rd_data_i,
    output logic  ok_o,
    output gate_t gate_o
);

    typedef enum logic [2:0] {F_IDLE, F_LO, F_WLO, F_HI, F_WHI} fetch_st_e;

    fetch_st_e st_q;
    word_t     addr_q;
    word_t     lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= F_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            case (st_q)
                F_IDLE: if (go_i) begin
                    st_q   <= F_LO;
                    addr_q <= base_addr_i;
                end
                F_LO:   st_q <= F_WLO;
                F_WLO:  if (rd_valid_i) begin
                    lo_q <= rd_data_i;
                    st_q <= F_HI;
                end
                F_HI:   st_q <= F_WHI;
                F_WHI:  if (rd_valid_i) st_q <= F_IDLE;
                default: st_q <= F_IDLE;
            endcase
        end
    end

    assign rd_en_o   = (st_q == F_LO) || (st_q == F_HI);
    assign rd_addr_o = (st_q == F_HI) ? addr_q + word_t'(4) : addr_q;
    assign ok_o      = (st_q == F_WHI) && rd_valid_i;
    assign gate_o    = gate_decode(lo_q, rd_data_i);

    // R1
    rd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> !rd_en_o);

endmodule

// File: rtl/exc_frame_pusher.sv
module exc_frame_pusher
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  word_t             sp_i,
    input  frame_t            frame_i,
    input  logic [SLOT_W-1:0] first_i,
    input  logic [SLOT_W-1:0] last_i,
    output logic              wr_en_o,
    output word_t             wr_addr_o,
    output word_t             wr_data_o,
    output logic              last_o
);

    logic              run_q;
    logic [SLOT_W-1:0] idx_q;
    logic [SLOT_W-1:0] last_q;
    word_t             sp_q;
    frame_t            frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            idx_q   <= '0;
            last_q  <= '0;
            sp_q    <= '0;
            frame_q <= '0;
        end else if (load_i) begin
            run_q   <= 1'b1;
            idx_q   <= first_i;
            last_q  <= last_i;
            sp_q    <= sp_i;
            frame_q <= frame_i;
        end else if (run_q) begin
            sp_q  <= sp_q - word_t'(4);
            idx_q <= idx_q + 1'b1;
            if (last_o) run_q <= 1'b0;
        end
    end

    assign wr_en_o   = run_q;
    assign wr_addr_o = sp_q - word_t'(4);
    assign wr_data_o = frame_q[idx_q];
    assign last_o    = run_q && (idx_q == last_q);

    // R6
    push_descend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) - word_t'(4)));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int LIMIT_W  = 16,
    parameter int ENTRY_LG = 3,
    parameter int IF_BIT   = 9,
    parameter int GP_VEC   = 13,
    parameter int PF_VEC   = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  vec_i,
    input  logic [1:0]  cls_i,
    input  logic        has_err_i,
    input  logic [31:0] err_code_i,
    input  logic [31:0] fault_addr_i,
    input  logic [31:0] tbl_base_i,
    input  logic [15:0] tbl_limit_i,
    input  logic [15:0] cur_cs_i,
    input  logic [15:0] cur_ss_i,
    input  logic [31:0] cur_sp_i,
    input  logic [31:0] cur_flags_i,
    input  logic [31:0] cur_ip_i,
    input  logic [31:0] next_ip_i,
    input  logic [15:0] kern_ss_i,
    input  logic [31:0] kern_sp_i,
    output logic        rd_en_o,
    output logic [31:0] rd_addr_o,
    input  logic        rd_valid_i,
    input  logic [31:0] rd_data_i,
    output logic        wr_en_o,
    output logic [31:0] wr_addr_o,
    output logic [31:0] wr_data_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        gp_o,
    output logic [7:0]  fault_vec_o,
    output logic [15:0] new_cs_o,
    output logic [31:0] new_ip_o,
    output logic [15:0] new_ss_o,
    output logic [31:0] new_sp_o,
    output logic [31:0] new_flags_o,
    output logic [31:0] fault_lin_o
);

    localparam int    ENTRY_MAX = (1 << ENTRY_LG) - 1;
    localparam word_t IF_MASK   = word_t'(1) << IF_BIT;

    seq_st_e st_q;
    req_t    req_q;
    logic    gp_q;
    logic    trap_q;

    // table bounds for the incoming vector
    word_t entry_off;
    word_t entry_addr;
    logic  in_limit;
    logic  accept;
    logic  fetch_go;

    assign entry_off  = word_t'(vec_i) << ENTRY_LG;
    assign entry_addr = tbl_base_i + entry_off;
    assign in_limit   = (entry_off + word_t'(ENTRY_MAX)) <= word_t'(tbl_limit_i);
    assign accept     = (st_q == S_IDLE) && start_i;
    assign fetch_go   = accept && in_limit;

    // descriptor fetch
    logic  fetch_ok;
    gate_t gate;

    exc_gate_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .go_i        (fetch_go),
        .base_addr_i (entry_addr),
        .rd_en_o     (rd_en_o),
        .rd_addr_o   (rd_addr_o),
        .rd_valid_i  (rd_valid_i),
        .rd_data_i   (rd_data_i),
        .ok_o        (fetch_ok),
        .gate_o      (gate)
    );

    // frame plan, decided when the descriptor arrives
    logic              switch_stack;
    word_t             sp_start;
    frame_t            frame;
    logic [SLOT_W-1:0] first_slot;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W:0]   push_cnt;
    word_t             sp_final;
    logic              push_load;
    logic              push_last;

    always_comb begin
        switch_stack = gate.sel[1:0] != req_q.cs[1:0];
        sp_start     = switch_stack ? req_q.ksp : req_q.sp;
        frame[SLOT_SS]  = sel_zext(req_q.ss);
        frame[SLOT_SP]  = req_q.sp;
        frame[SLOT_FL]  = req_q.flags;
        frame[SLOT_CS]  = sel_zext(req_q.cs);
        frame[SLOT_IP]  = saves_next_ip(req_q.cls) ? req_q.nip : req_q.ip;
        frame[SLOT_ERR] = req_q.err;
        first_slot = switch_stack ? SLOT_W'(SLOT_SS) : SLOT_W'(SLOT_FL);
        last_slot  = req_q.has_err ? SLOT_W'(SLOT_ERR) : SLOT_W'(SLOT_IP);
        push_cnt   = {1'b0, last_slot} - {1'b0, first_slot} + 1'b1;
        sp_final   = sp_start - (word_t'(push_cnt) << 2);
    end

    assign push_load = (st_q == S_FETCH) && fetch_ok && gate.present;

    exc_frame_pusher u_push (
        .clk       (clk),
        .rst       (rst),
        .load_i    (push_load),
        .sp_i      (sp_start),
        .frame_i   (frame),
        .first_i   (first_slot),
        .last_i    (last_slot),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .last_o    (push_last)
    );

    // sequence control and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            req_q       <= '0;
            gp_q        <= 1'b0;
            trap_q      <= 1'b0;
            fault_vec_o <= '0;
            new_cs_o    <= '0;
            new_ip_o    <= '0;
            new_ss_o    <= '0;
            new_sp_o    <= '0;
            new_flags_o <= '0;
            fault_lin_o <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start_i) begin
                    req_q <= '{vec: vec_i, cls: exc_cls_e'(cls_i), has_err: has_err_i,
                               err: err_code_i, cs: cur_cs_i, ss: cur_ss_i, sp: cur_sp_i,
                               flags: cur_flags_i, ip: cur_ip_i, nip: next_ip_i,
                               kss: kern_ss_i, ksp: kern_sp_i};
                    if (vec_i == 8'(PF_VEC)) fault_lin_o <= fault_addr_i;
                    if (in_limit) begin
                        st_q <= S_FETCH;
                    end else begin
                        st_q        <= S_DONE;
                        gp_q        <= 1'b1;
                        fault_vec_o <= 8'(GP_VEC);
                    end
                end
                S_FETCH: if (fetch_ok) begin
                    if (!gate.present) begin
                        st_q        <= S_DONE;
                        gp_q        <= 1'b1;
                        fault_vec_o <= 8'(GP_VEC);
                    end else begin
                        st_q        <= S_PUSH;
                        gp_q        <= 1'b0;
                        trap_q      <= gate.trap;
                        fault_vec_o <= req_q.vec;
                        new_cs_o    <= gate.sel;
                        new_ip_o    <= gate.off;
                        new_ss_o    <= switch_stack ? req_q.kss : req_q.ss;
                        new_sp_o    <= sp_final;
                        new_flags_o <= gate.trap ? req_q.flags : (req_q.flags & ~IF_MASK);
                    end
                end
                S_PUSH: if (push_last) st_q <= S_DONE;
                S_DONE: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o = st_q != S_IDLE;
    assign done_o = st_q == S_DONE;
    assign gp_o   = done_o && gp_q;

    // R10
    wr_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (busy_o && !done_o && !rd_en_o));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R3
    gp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        gp_o |-> ($past(!wr_en_o) && !wr_en_o));

    // R8
    irq_gate_if_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !gp_o && !trap_q) |-> !new_flags_o[IF_BIT]);

    // R11
    gp_vec_chk: assert property (@(posedge clk) disable iff (rst)
        gp_o |-> (fault_vec_o == 8'(GP_VEC)));

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

    localparam logic [31:0] TBASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  vec = '0;
    logic [1:0]  cls = '0;
    logic        has_err = 1'b0;
    logic [31:0] err_code = '0;
    logic [31:0] fault_addr = '0;
    logic [31:0] tbl_base = TBASE;
    logic [15:0] tbl_limit = 16'h07FF;
    logic [15:0] cur_cs = '0;
    logic [15:0] cur_ss = '0;
    logic [31:0] cur_sp = '0;
    logic [31:0] cur_flags = '0;
    logic [31:0] cur_ip = '0;
    logic [31:0] next_ip = '0;
    logic [15:0] kern_ss = '0;
    logic [31:0] kern_sp = '0;
    logic        rd_en, rd_valid, wr_en, busy, done, gp;
    logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
    logic [7:0]  fault_vec;
    logic [15:0] new_cs, new_ss;
    logic [31:0] new_ip, new_sp, new_flags, fault_lin;

    always #2.5 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start), .vec_i(vec), .cls_i(cls),
        .has_err_i(has_err), .err_code_i(err_code), .fault_addr_i(fault_addr),
        .tbl_base_i(tbl_base), .tbl_limit_i(tbl_limit), .cur_cs_i(cur_cs),
        .cur_ss_i(cur_ss), .cur_sp_i(cur_sp), .cur_flags_i(cur_flags),
        .cur_ip_i(cur_ip), .next_ip_i(next_ip), .kern_ss_i(kern_ss), .kern_sp_i(kern_sp),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .gp_o(gp), .fault_vec_o(fault_vec),
        .new_cs_o(new_cs), .new_ip_o(new_ip), .new_ss_o(new_ss), .new_sp_o(new_sp),
        .new_flags_o(new_flags), .fault_lin_o(fault_lin)
    );

    // descriptor memory and its behavioural read port
    logic [31:0] mem [0:511];
    logic [15:0] g_sel [0:255];
    logic [31:0] g_off [0:255];
    bit          g_p   [0:255];
    bit          g_t   [0:255];
    int          rd_lat = 0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic [8:0]  ridx = '0;

    always @(posedge clk) begin
        if (rd_en) begin
            pend <= 1'b1;
            cnt  <= rd_lat;
            ridx <= 9'((rd_addr - TBASE) >> 2);
        end else if (pend) begin
            if (cnt == 0) pend <= 1'b0;
            else cnt <= cnt - 1;
        end
    end
    assign rd_valid = pend && (cnt == 0);
    assign rd_data  = mem[ridx];

    task automatic set_gate(input int v, input logic [15:0] s, input logic [31:0] o,
                            input bit p, input bit t);
        mem[2*v]   = {s, o[15:0]};
        mem[2*v+1] = {o[31:16], p, 2'b00, 4'b0000, t, 8'h00};
        g_sel[v] = s; g_off[v] = o; g_p[v] = p; g_t[v] = t;
    endtask

    int  nvec = 0;
    int  nbad = 0;
    bit  finished = 1'b0;
    bit  hold_start = 1'b0;
    logic [15:0] e_cs = '0, e_ss = '0;
    logic [31:0] e_ip = '0, e_sp = '0, e_fl = '0, e_fa = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model: expected schedule, frame and results for one start
    task automatic run_case(input string tag);
        logic [31:0] qa[$];
        logic [31:0] qd[$];
        logic [31:0] spw, ent;
        bit lim_gp, np_gp, sw;
        int dcyc, wlo, whi, npush;
        ent    = TBASE + {21'd0, vec, 3'b000};
        lim_gp = ({21'd0, vec, 3'b111} > {16'd0, tbl_limit});
        np_gp  = !lim_gp && !g_p[vec];
        if (vec == 8'd14) e_fa = fault_addr;
        npush = 0;
        if (lim_gp) dcyc = 1;
        else if (np_gp) dcyc = 5 + 2*rd_lat;
        else begin
            sw  = g_sel[vec][1:0] != cur_cs[1:0];
            spw = sw ? kern_sp : cur_sp;
            if (sw) begin
                spw -= 4; qa.push_back(spw); qd.push_back({16'd0, cur_ss});
                spw -= 4; qa.push_back(spw); qd.push_back(cur_sp);
            end
            spw -= 4; qa.push_back(spw); qd.push_back(cur_flags);
            spw -= 4; qa.push_back(spw); qd.push_back({16'd0, cur_cs});
            spw -= 4; qa.push_back(spw);
            qd.push_back((cls == 2'd1 || cls == 2'd2) ? next_ip : cur_ip);
            if (has_err) begin spw -= 4; qa.push_back(spw); qd.push_back(err_code); end
            npush = qa.size();
            dcyc  = 5 + 2*rd_lat + npush;
            e_cs = g_sel[vec]; e_ip = g_off[vec];
            e_ss = sw ? kern_ss : cur_ss; e_sp = spw;
            e_fl = g_t[vec] ? cur_flags : (cur_flags & ~32'h0000_0200);
        end
        wlo = 5 + 2*rd_lat;
        whi = wlo + npush - 1;
        start = 1'b1;
        for (int k = 1; k <= dcyc + 1; k++) begin
            @(negedge clk);
            start = hold_start && (k < dcyc);
            chk({tag, " R10 busy"}, {31'd0, busy}, {31'd0, k <= dcyc});
            chk({tag, " R10 done"}, {31'd0, done}, {31'd0, k == dcyc});
            if (k == 1 && !lim_gp) begin
                chk({tag, " R1 rd lo"}, {rd_en, rd_addr}, {1'b1, ent});
            end else if (k == 3 + rd_lat && !lim_gp) begin
                chk({tag, " R1 rd hi"}, {rd_en, rd_addr}, {1'b1, ent + 32'd4});
            end else begin
                chk({tag, " R1 no rd"}, {31'd0, rd_en}, 32'd0);
            end
            if (k >= wlo && k <= whi) begin
                chk({tag, " R6 wr en"}, {31'd0, wr_en}, 32'd1);
                chk({tag, " R4 R6 wr addr"}, wr_addr, qa.pop_front());
                chk({tag, " R6 R7 wr data"}, wr_data, qd.pop_front());
            end else begin
                chk({tag, " R3 no wr"}, {31'd0, wr_en}, 32'd0);
            end
            if (k == dcyc) begin
                chk({tag, " R11 gp"}, {31'd0, gp}, {31'd0, lim_gp || np_gp});
                chk({tag, " R11 vec"}, {24'd0, fault_vec},
                    (lim_gp || np_gp) ? 32'd13 : {24'd0, vec});
                chk({tag, " R2 cs"}, {16'd0, new_cs}, {16'd0, e_cs});
                chk({tag, " R2 ip"}, new_ip, e_ip);
                chk({tag, " R4 R5 ss"}, {16'd0, new_ss}, {16'd0, e_ss});
                chk({tag, " R6 sp"}, new_sp, e_sp);
                chk({tag, " R8 flags"}, new_flags, e_fl);
                chk({tag, " R9 fault addr"}, fault_lin, e_fa);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        for (int v = 0; v < 256; v++) begin
            g_sel[v] = '0; g_off[v] = '0; g_p[v] = 0; g_t[v] = 0;
        end
        set_gate(32,  16'h0008, 32'hC010_2040, 1, 0);
        set_gate(14,  16'h0008, 32'hC010_1400, 1, 0);
        set_gate(3,   16'h0008, 32'hC010_0300, 1, 1);
        set_gate(8,   16'h001B, 32'h0040_0800, 1, 1);
        set_gate(39,  16'h0008, 32'h1234_5678, 1, 1);
        set_gate(255, 16'h0008, 32'hFFFF_0001, 1, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset busy",   {31'd0, busy}, 32'd0);
        chk("reset done",   {31'd0, done}, 32'd0);
        chk("reset wr",     {31'd0, wr_en}, 32'd0);
        chk("reset rd",     {31'd0, rd_en}, 32'd0);
        chk("reset sp",     new_sp, 32'd0);
        chk("reset R9 lin", fault_lin, 32'd0);

        // hardware interrupt, same privilege, interrupt gate
        vec = 8'd32; cls = 2'd2; has_err = 0; cur_cs = 16'h0008; cur_ss = 16'h0010;
        cur_sp = 32'h0000_8000; cur_flags = 32'h0000_0246; cur_ip = 32'h100; next_ip = 32'h104;
        kern_ss = 16'h0010; kern_sp = 32'h0009_0000; fault_addr = 32'hDEAD_0000;
        run_case("irq-same R5");

        // page fault from user, error code, slow memory
        rd_lat = 2; vec = 8'd14; cls = 2'd0; has_err = 1; err_code = 32'h0000_0006;
        cur_cs = 16'h001B; cur_ss = 16'h0023; cur_sp = 32'h00BF_FF00; cur_flags = 32'h0000_0202;
        cur_ip = 32'h0080_1234; next_ip = 32'h0080_1238; fault_addr = 32'h0000_5FFC;
        run_case("pf-user R4 R9");

        // trap gate from user, flags kept, next instruction saved
        rd_lat = 0; vec = 8'd3; cls = 2'd1; has_err = 0; fault_addr = 32'h1111_1111;
        run_case("trap-user R8");

        // abort class, same privilege user gate, held start ignored
        vec = 8'd8; cls = 2'd3; has_err = 1; err_code = 32'h0; hold_start = 1;
        run_case("abort R7 R10");
        hold_start = 0;

        // descriptor not present
        vec = 8'd50; cls = 2'd2; has_err = 0; rd_lat = 1;
        run_case("np R3");

        // limit boundary: last entry inside, next outside
        rd_lat = 0; tbl_limit = 16'd319; vec = 8'd39; cls = 2'd0; cur_cs = 16'h0008;
        run_case("lim-in R1");
        vec = 8'd40;
        run_case("lim-out R1");
        vec = 8'd14; fault_addr = 32'h0000_ABCD;
        run_case("lim-out-pf R9");

        // top vector of a full table
        tbl_limit = 16'h07FF; vec = 8'd255; cls = 2'd2; has_err = 1; err_code = 32'h5A5A;
        cur_flags = 32'h0000_0000;
        run_case("vec255 R2");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule